// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM Timer

This block is a register-mapped pulse-width modulator. One free-running counter is shared by several compare channels. A power-of-two scale setting shifts the counter right. The low 16 bits of the shifted value form the scaled count. Each channel compares the scaled count with its own 16-bit threshold and drives one output pin. The output is inverted: it stays low while the scaled count is below the threshold and goes high from the threshold to the end of the period. There is no period register. A period always spans 2^(16+scale) clock ticks, because the 16-bit scaled count wraps on its own.

Software reaches the block through a plain single-cycle port. A write takes effect at the next rising clock edge, and read data is combinational from the address. The port gives access to a control word, the raw counter, the scaled counter and one threshold register per channel. Writes to a threshold or to the control word are applied at once, with no holding until the period boundary. A period can therefore mix an old duty with a new length. Each channel has a pending flag that is set when its output rises. Software clears the flag through the control word.

Top module: `scaled_pwm_timer`

## Requirements
- R1: After reset the control word, the raw counter and every threshold read as zero, the counter stays still, no pending flag is set and every output is high.
- R2: The raw counter rises by exactly one per clock while the run bit (control bit 12) is 1. It holds its value while that bit is 0.
- R3: The scaled count, read at offset 0x10, equals the raw counter shifted right by the scale field (control bits 3:0, values 0 to 15), truncated to 16 bits. One period therefore lasts 2^(16+scale) ticks.
- R4: Channel i's output is low while the scaled count is below its threshold and high otherwise. A threshold of 0 keeps the output high at all times.
- R5: A threshold of 0xFFFF still gives a high output when the scaled count is 0xFFFF, so a fully low period cannot be produced.
- R6: A write to a threshold changes the output from the next clock on, even in the middle of a period.
- R7: Channel i's pending flag sits at control bit 28+i. It is set in the clock after the output goes from low to high. A control write loads it from the written bit: writing 0 clears it and writing 1 sets it. Without a write or a new rise it keeps its value.
- R8: The raw counter, 31 bits at offset 0x08, can be written, and the write has priority over counting. Writes to the scaled count at offset 0x10 are ignored.
- R9: Control bits 8, 9, 10, 13, 16 and 24 are stored and read back, but they do not affect counting or the outputs. Other bits that are not in use read as 0.
- R10: Threshold i sits at offset 0x20+4*i and reads back its 16-bit value. Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_o | output | 4 | Inverted PWM output, one bit per channel |

## Verification
Four properties are checked on every cycle:
- the counter holds while stopped, steps by one while running and loads a written value;
- a zero threshold always gives a high output;
- a saturated scaled count always gives a high output;
- a rising output always sets its pending flag, and the flag stays set until a control write.

The bench scenarios cover what those properties cannot: the shift arithmetic over random scale settings and counter values, the output levels against random thresholds, the register map and the read-back of stored bits, the ignored write to the scaled count, and a threshold rewrite in the middle of a period.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
   localparam int DATA_W      = 32;
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_RAW     = 'h08;
   localparam int OFS_SCALED  = 'h10;
   localparam int OFS_THR0    = 'h20;
   localparam int THR_STRIDE  = 4;
   localparam int RUN_BIT     = 12;
   localparam int FLAG_LSB    = 28;
   localparam int MAX_CH      = DATA_W - FLAG_LSB;
   // scale[3:0], stored-only bits 8,9,10,13,16,24, run bit 12
   localparam logic [DATA_W-1:0] KEEP_MASK = 32'h0101_370F;
endpackage

// File: rtl/spwm_counter.sv
module spwm_counter #(
   parameter int CMP_W   = 16,
   parameter int SCALE_W = 4,
   localparam int CNT_W  = CMP_W + (1 << SCALE_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               load,
   input  logic [CNT_W-1:0]   load_val,
   input  logic [SCALE_W-1:0] scale,
   output logic [CNT_W-1:0]   count,
   output logic [CMP_W-1:0]   scaled
);
   logic [CNT_W-1:0] shifted;

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (run)  count <= count + 1'b1;
   end

   always_comb begin
      shifted = count >> scale;
      scaled  = shifted[CMP_W-1:0];
   end

   assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> (count == CNT_W'($past(count) + 1'b1)));
   assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
   parameter int CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] scaled,
   input  logic             thr_wr,
   input  logic [CMP_W-1:0] thr_wdata,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   output logic [CMP_W-1:0] thr_q,
   output logic             pwm_o,
   output logic             flag_o
);
   logic prev_q;
   logic rise;

   always_comb begin
      pwm_o = (scaled >= thr_q);
      rise  = pwm_o & ~prev_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q  <= '0;
         prev_q <= 1'b1;
         flag_o <= 1'b0;
      end else begin
         if (thr_wr) thr_q <= thr_wdata;
         prev_q <= pwm_o;
         flag_o <= (flag_wr ? flag_wdata : flag_o) | rise;
      end
   end

   assert_zero_thr_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q == '0) |-> pwm_o);
   assert_never_full_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scaled == '1) |-> pwm_o);
   assert_rise_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_o) && !flag_wr) |=> flag_o);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_wr) |=> flag_o);
endmodule

// File: rtl/scaled_pwm_timer.sv
module scaled_pwm_timer
   import spwm_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CMP_W   = 16,
   parameter int SCALE_W = 4,
   parameter int ADDR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wen,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_CH-1:0]   pwm_o
);
   localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and the flag field width");
   end
   if (SCALE_W < 1 || SCALE_W > 4) begin : g_bad_scale
      $error("SCALE_W must fit the 4-bit scale field");
   end
   if (CNT_W > DATA_W || CMP_W > DATA_W) begin : g_bad_width
      $error("counter or threshold wider than the data word");
   end
   if (OFS_THR0 + THR_STRIDE * NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
      $error("threshold registers exceed the address space");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              ctrl_wr, raw_wr;
   logic [CNT_W-1:0]  count;
   logic [CMP_W-1:0]  scaled;
   logic [NUM_CH-1:0] flags;
   logic [CMP_W-1:0]  thr_rd [NUM_CH];
   logic [NUM_CH-1:0] thr_hit;

   assign ctrl_wr = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
   assign raw_wr  = bus_wen && (bus_addr == ADDR_W'(OFS_RAW));

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= bus_wdata & KEEP_MASK;
   end

   spwm_counter #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[RUN_BIT]),
      .load     (raw_wr),
      .load_val (bus_wdata[CNT_W-1:0]),
      .scale    (ctrl_q[SCALE_W-1:0]),
      .count    (count),
      .scaled   (scaled)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign thr_hit[ch] = (bus_addr == ADDR_W'(OFS_THR0 + THR_STRIDE * ch));
      spwm_channel #(.CMP_W(CMP_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .scaled     (scaled),
         .thr_wr     (bus_wen && thr_hit[ch]),
         .thr_wdata  (bus_wdata[CMP_W-1:0]),
         .flag_wr    (ctrl_wr),
         .flag_wdata (bus_wdata[FLAG_LSB+ch]),
         .thr_q      (thr_rd[ch]),
         .pwm_o      (pwm_o[ch]),
         .flag_o     (flags[ch])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata = ctrl_q;
         bus_rdata[FLAG_LSB +: NUM_CH] = flags;
      end else if (bus_addr == ADDR_W'(OFS_RAW)) begin
         bus_rdata = DATA_W'(count);
      end else if (bus_addr == ADDR_W'(OFS_SCALED)) begin
         bus_rdata = DATA_W'(scaled);
      end else begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            if (thr_hit[ch]) bus_rdata = DATA_W'(thr_rd[ch]);
         end
      end
   end

   assert_stopped_after_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && ctrl_q == '0));
endmodule

// File: tb/scaled_pwm_timer_bench.sv
module scaled_pwm_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] pwm_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] rd;
   logic [15:0] thr [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   scaled_pwm_timer u_scaled_pwm_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o));

   function automatic logic [15:0] exp_scaled(logic [30:0] cnt, int sc);
      logic [30:0] s;
      s = cnt >> sc;
      return s[15:0];
   endfunction

   function automatic logic [NCH-1:0] exp_pwm(logic [15:0] sv);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = (sv >= thr[i]);
      return r;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rdreg(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_thr(int i, logic [15:0] v);
      thr[i] = v;
      wr(8'h20 + 8'(4*i), {16'h0, v});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [30:0] c;
      void'($urandom(32'd1234));
      for (int i = 0; i < NCH; i++) thr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdreg(8'h00, rd); check("R1 ctrl", rd, 0);
      rdreg(8'h08, rd); check("R1 raw", rd, 0);
      repeat (4) @(negedge clk);
      rdreg(8'h08, rd); check("R1 stopped", rd, 0);
      for (int i = 0; i < NCH; i++) begin
         rdreg(8'h20 + 8'(4*i), rd); check("R1 thr", rd, 0);
      end
      check("R1 outputs high", 32'(pwm_o), 32'hF);

      // R8 raw write, scaled write ignored; R2 hold while stopped
      wr(8'h08, 32'h0000_1234);
      rdreg(8'h08, rd); check("R8 raw write", rd, 32'h1234);
      wr(8'h10, 32'h0000_BEEF);
      rdreg(8'h10, rd); check("R8 scaled write ignored", rd, 32'h1234);
      repeat (5) @(negedge clk);
      rdreg(8'h08, rd); check("R2 hold when stopped", rd, 32'h1234);

      // R3 / R4 random scale, counter and thresholds
      for (int it = 0; it < 24; it++) begin
         int sc;
         logic [15:0] sv;
         sc = int'($urandom_range(15, 0));
         c = 31'($urandom);
         wr(8'h00, 32'(sc));
         wr(8'h08, {1'b0, c});
         for (int i = 0; i < NCH; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            if (it % 6 == 0) v = 16'h0;
            if (it % 6 == 1) v = 16'hFFFF;
            set_thr(i, v);
         end
         sv = exp_scaled(c, sc);
         rdreg(8'h10, rd); check("R3 scaled count", rd, {16'h0, sv});
         #1; check("R4 output levels", 32'(pwm_o), 32'(exp_pwm(sv)));
      end

      // R3 largest scale
      wr(8'h00, 32'd15);
      wr(8'h08, 32'h7FFF_FFFF);
      rdreg(8'h10, rd); check("R3 scale 15 max", rd, 32'hFFFF);

      // R5 no full-low period
      wr(8'h00, 32'd0);
      for (int i = 0; i < NCH; i++) set_thr(i, 16'h0);
      set_thr(0, 16'hFFFF);
      wr(8'h08, 32'h0000_FFFE);
      #1; check("R5 low just below max", 32'(pwm_o[0]), 0);
      wr(8'h08, 32'h0001_FFFF);
      #1; check("R5 high at saturation", 32'(pwm_o[0]), 1);

      // R6 threshold change mid-period
      wr(8'h08, 32'h0000_0100);
      set_thr(0, 16'h0080);
      #1; check("R6 high above thr", 32'(pwm_o[0]), 1);
      set_thr(0, 16'h0200);
      #1; check("R6 immediate new thr", 32'(pwm_o[0]), 0);

      // R2 counting and R9 stored-only bits
      wr(8'h08, 32'h0000_0040);
      wr(8'h00, 32'h0101_3700 | 32'h1000);
      rdreg(8'h00, rd); check("R9 stored bits readback", rd, 32'h0101_3700 | 32'h1000);
      rdreg(8'h08, rd); check("R2 start value", rd, 32'h40);
      repeat (37) @(negedge clk);
      rdreg(8'h08, rd); check("R2 counted one per clock", rd, 32'h40 + 37);
      check("R9 no effect on outputs", 32'(pwm_o[0]), 0);
      wr(8'h00, 32'hFFFF_FFFF & ~32'hF000_0000 & ~32'h0000_1000);
      rdreg(8'h00, rd); check("R9 unused bits read 0", rd, 32'h0101_270F);
      rdreg(8'h08, rd); c = rd[30:0];
      repeat (6) @(negedge clk);
      rdreg(8'h08, rd); check("R2 stops when run clear", rd, {1'b0, c});

      // R7 pending flag
      for (int i = 1; i < NCH; i++) set_thr(i, 16'h0);
      wr(8'h08, 32'h0000_0050);
      set_thr(0, 16'h0060);
      wr(8'h00, 32'h0);
      rdreg(8'h00, rd); check("R7 flags cleared", rd, 32'h0);
      wr(8'h00, 32'h0000_1000);
      repeat (32) @(negedge clk);
      rdreg(8'h00, rd); check("R7 flag set on rise", rd, 32'h1000_1000);
      wr(8'h00, 32'h0000_1000);
      rdreg(8'h00, rd); check("R7 flag cleared by write 0", rd, 32'h0000_1000);
      wr(8'h00, 32'h2000_0000);
      rdreg(8'h00, rd); check("R7 flag set by write 1", rd, 32'h2000_0000);

      // R10 register map
      set_thr(3, 16'hA5C3);
      rdreg(8'h2C, rd); check("R10 thr3 offset", rd, 32'hA5C3);
      rdreg(8'h04, rd); check("R10 unmapped 0x04", rd, 0);
      rdreg(8'h30, rd); check("R10 unmapped 0x30", rd, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule